// File: doc/BRIEF.md
# Motor Drive Command Arbiter

This block sits between the external control pins of a three-phase motor controller and its commutation stage. It cleans up three asynchronous control inputs (a brake request, a rotation direction and a drive-disable), and lets each of the first two be replaced by a value that software writes. From these inputs it decides one drive state per clock cycle: run, ramp-to-brake, brake, coast or restart. Alongside the state it supplies a speed target, the braking style to apply and the phase order.

A brake request does not stop the motor at once. The block first limits the speed target to a programmable threshold. It moves into the brake state only when the measured speed has fallen to that threshold or below. The drive-disable input overrides everything else and forces all output switches off. When it is released, the block asks the start sequencer for a fresh start and does not resume where it left off. It holds a start-required indication until the sequencer acknowledges it. A direction change takes effect only while the motor is not being driven, so the phase order never flips under a spinning rotor.

Top module: `drive_cmd_arbiter`

## Requirements
- R1: Each pin passes a two-flop synchroniser and then a glitch filter of length `filt_len`. A level change held at the pin reaches the filtered value on the (3+`filt_len`)-th rising edge and the drive state on the next edge. A synchronised pulse shorter than `filt_len`+1 cycles is dropped.
- R2: When `brake_ovr_en`=1 the effective brake value is `brake_ovr_val` and the pin is ignored. When `dir_ovr_en`=1 the same holds for `dir_ovr_val`. Clearing the enable hands control back to the filtered pin on the next cycle.
- R3: An effective drive-disable of 1 moves the state to coast (`drive_state`=3) on the next edge, whatever the state and the other inputs are. In coast `coast`=1, `speed_target`=0 and `brake_kind`=0.
- R4: Leaving coast always enters restart (`drive_state`=4). `restart_pulse` is 1 for exactly the first cycle of every restart state.
- R5: `coast` is 1 in coast and in restart until `seq_ack` is seen. At that point the state moves to run (`drive_state`=0), or to ramp if the brake is active, and `coast` drops.
- R6: An active brake in run moves the state to ramp (`drive_state`=1). In ramp `speed_target` = min(`speed_req`, `brake_thr`). In run it is `speed_req`.
- R7: In ramp the state moves to brake (`drive_state`=2) when `speed_est` <= `brake_thr`, and otherwise stays in ramp. Releasing the brake in ramp returns to run.
- R8: In brake `brake_kind` is 1 (low-side) when `brake_mode`=0 and 2 (align) when `brake_mode`=1. It is 0 in every other state. `speed_target` is 0 in brake.
- R9: The state stays in brake while the brake is active. Releasing the brake enters restart.
- R10: `dir_fwd`=1 means phase order A, B, C and 0 means A, C, B. It copies the effective direction one cycle later only while the state is coast or restart, and holds in run, ramp and brake.
- R11: During reset the state is coast with `coast`=1, `restart_pulse`=0, `dir_fwd`=1, `speed_target`=0 and `brake_kind`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| brake_pin | input | 1 | Asynchronous brake request pin |
| dir_pin | input | 1 | Asynchronous direction pin |
| drvoff_pin | input | 1 | Asynchronous drive-disable pin |
| brake_ovr_en | input | 1 | Take brake from register value |
| brake_ovr_val | input | 1 | Register brake value |
| dir_ovr_en | input | 1 | Take direction from register value |
| dir_ovr_val | input | 1 | Register direction value |
| brake_mode | input | 1 | 0 low-side braking, 1 align braking |
| filt_len | input | FLT_W | Glitch filter length |
| brake_thr | input | SPD_W | Speed at or below which braking starts |
| speed_est | input | SPD_W | Present speed estimate |
| speed_req | input | SPD_W | Demanded speed |
| seq_ack | input | 1 | Start sequencer acknowledge |
| speed_target | output | SPD_W | Clamped speed target |
| drive_state | output | 3 | 0 run, 1 ramp, 2 brake, 3 coast, 4 restart |
| brake_kind | output | 2 | 0 none, 1 low-side, 2 align |
| dir_fwd | output | 1 | Phase order select |
| restart_pulse | output | 1 | One-cycle restart request |
| coast | output | 1 | Switches off / start required |

## Verification
A wrong state register shows up at `drive_state`, `speed_target` and `brake_kind` in the cycle right after the faulty edge. A lost pending-start bit shows up as `coast` falling before `seq_ack`. A direction latch that is opened at the wrong time shows up at `dir_fwd` one cycle after the direction input moves while the motor is running. A filter counter that is off by one moves the arrival of drive-disable at `drive_state` by a cycle, which the bench samples on the exact edge. The bench sweeps the speed estimate over the full range around the threshold, for both braking styles and for demands above and below the threshold.

// File: rtl/mdca_pkg.sv
package mdca_pkg;

    typedef enum logic [2:0] {
        DS_RUN     = 3'd0,
        DS_RAMP    = 3'd1,
        DS_BRAKE   = 3'd2,
        DS_COAST   = 3'd3,
        DS_RESTART = 3'd4
    } drive_state_e;

    typedef enum logic [1:0] {
        BK_NONE    = 2'd0,
        BK_LOWSIDE = 2'd1,
        BK_ALIGN   = 2'd2
    } brake_kind_e;

    typedef struct packed {
        logic drvoff;
        logic dir;
        logic brake;
    } cmd_set_t;

    localparam int NUM_PINS = 3;
    localparam logic [NUM_PINS-1:0] PIN_RESET = 3'b010;

    function automatic logic [15:0] umin16(input logic [15:0] a, input logic [15:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/pin_conditioner.sv
module pin_conditioner #(
    parameter int   FLT_W   = 4,
    parameter logic RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_async,
    input  logic [FLT_W-1:0] filt_len,
    output logic             pin_clean
);
    logic             meta_q;
    logic             sync_q;
    logic             filt_q;
    logic [FLT_W-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= pin_async;
            sync_q <= meta_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            filt_q  <= RST_VAL;
            run_cnt <= '0;
        end else if (sync_q == filt_q) begin
            run_cnt <= '0;
        end else if (run_cnt == filt_len) begin
            filt_q  <= sync_q;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assign pin_clean = filt_q;

    // R1
    filt_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(filt_q) |-> (filt_q == $past(sync_q)));

endmodule

// File: rtl/cmd_select.sv
module cmd_select
    import mdca_pkg::*;
(
    input  logic     brake_clean,
    input  logic     dir_clean,
    input  logic     drvoff_clean,
    input  logic     brake_ovr_en,
    input  logic     brake_ovr_val,
    input  logic     dir_ovr_en,
    input  logic     dir_ovr_val,
    output cmd_set_t eff
);
    always_comb begin
        eff.drvoff = drvoff_clean;
        eff.brake  = brake_ovr_en ? brake_ovr_val : brake_clean;
        eff.dir    = dir_ovr_en   ? dir_ovr_val   : dir_clean;
    end
endmodule

// File: rtl/speed_clamp.sv
module speed_clamp
    import mdca_pkg::*;
#(
    parameter int SPD_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  drive_state_e     state,
    input  logic [SPD_W-1:0] speed_req,
    input  logic [SPD_W-1:0] brake_thr,
    output logic [SPD_W-1:0] speed_target
);
    logic [15:0] lim;

    always_comb begin
        lim = umin16(16'(speed_req), 16'(brake_thr));
        case (state)
            DS_RUN:  speed_target = speed_req;
            DS_RAMP: speed_target = lim[SPD_W-1:0];
            default: speed_target = '0;
        endcase
    end

    // R6
    ramp_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        (state == DS_RAMP) |-> (speed_target <= brake_thr));

endmodule

// File: rtl/drive_fsm.sv
module drive_fsm
    import mdca_pkg::*;
#(
    parameter int SPD_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  cmd_set_t         eff,
    input  logic             brake_mode,
    input  logic [SPD_W-1:0] brake_thr,
    input  logic [SPD_W-1:0] speed_est,
    input  logic             seq_ack,
    output drive_state_e     state,
    output brake_kind_e      brake_kind,
    output logic             dir_fwd,
    output logic             restart_pulse,
    output logic             coast
);
    drive_state_e state_q, state_d;
    logic         start_req_q, start_req_d;
    logic         dir_q;
    logic         restart_q;
    logic         slow_enough;

    assign slow_enough = (speed_est <= brake_thr);

    always_comb begin
        state_d     = state_q;
        start_req_d = start_req_q;
        if (eff.drvoff) begin
            state_d     = DS_COAST;
            start_req_d = 1'b1;
        end else begin
            case (state_q)
                DS_COAST:   state_d = DS_RESTART;
                DS_RESTART: begin
                    if (seq_ack) begin
                        start_req_d = 1'b0;
                        state_d     = eff.brake ? DS_RAMP : DS_RUN;
                    end
                end
                DS_RUN:     if (eff.brake) state_d = DS_RAMP;
                DS_RAMP: begin
                    if (!eff.brake)       state_d = DS_RUN;
                    else if (slow_enough) state_d = DS_BRAKE;
                end
                DS_BRAKE: begin
                    if (!eff.brake) begin
                        state_d     = DS_RESTART;
                        start_req_d = 1'b1;
                    end
                end
                default:    state_d = DS_COAST;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= DS_COAST;
            start_req_q <= 1'b1;
            restart_q   <= 1'b0;
            dir_q       <= 1'b1;
        end else begin
            state_q     <= state_d;
            start_req_q <= start_req_d;
            restart_q   <= (state_d == DS_RESTART) && (state_q != DS_RESTART);
            if (state_q == DS_COAST || state_q == DS_RESTART)
                dir_q <= eff.dir;
        end
    end

    always_comb begin
        if (state_q == DS_BRAKE)
            brake_kind = brake_mode ? BK_ALIGN : BK_LOWSIDE;
        else
            brake_kind = BK_NONE;
    end

    assign state         = state_q;
    assign dir_fwd       = dir_q;
    assign restart_pulse = restart_q;
    assign coast         = (state_q == DS_COAST) || start_req_q;

    // R3
    drvoff_coast_chk: assert property (@(posedge clk) disable iff (rst)
        eff.drvoff |=> (state_q == DS_COAST));

    // R4
    restart_once_chk: assert property (@(posedge clk) disable iff (rst)
        restart_q |=> !restart_q);

    // R7
    brake_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == DS_BRAKE && $past(state_q) != DS_BRAKE)
        |-> ($past(state_q) == DS_RAMP && $past(speed_est) <= $past(brake_thr)));

    // R10
    dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == DS_RUN && $past(state_q) == DS_RUN) |-> $stable(dir_q));

    // R5
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == DS_RESTART && seq_ack && !eff.drvoff) |=> !coast);

endmodule

// File: rtl/drive_cmd_arbiter.sv
module drive_cmd_arbiter
    import mdca_pkg::*;
#(
    parameter int SPD_W = 8,
    parameter int FLT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             brake_pin,
    input  logic             dir_pin,
    input  logic             drvoff_pin,
    input  logic             brake_ovr_en,
    input  logic             brake_ovr_val,
    input  logic             dir_ovr_en,
    input  logic             dir_ovr_val,
    input  logic             brake_mode,
    input  logic [FLT_W-1:0] filt_len,
    input  logic [SPD_W-1:0] brake_thr,
    input  logic [SPD_W-1:0] speed_est,
    input  logic [SPD_W-1:0] speed_req,
    input  logic             seq_ack,
    output logic [SPD_W-1:0] speed_target,
    output logic [2:0]       drive_state,
    output logic [1:0]       brake_kind,
    output logic             dir_fwd,
    output logic             restart_pulse,
    output logic             coast
);
    logic [NUM_PINS-1:0] raw_pins;
    logic [NUM_PINS-1:0] clean_pins;
    cmd_set_t            eff;
    drive_state_e        state;
    brake_kind_e         kind;

    assign raw_pins = {drvoff_pin, dir_pin, brake_pin};

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        pin_conditioner #(
            .FLT_W   (FLT_W),
            .RST_VAL (PIN_RESET[i])
        ) u_cond (
            .clk       (clk),
            .rst       (rst),
            .pin_async (raw_pins[i]),
            .filt_len  (filt_len),
            .pin_clean (clean_pins[i])
        );
    end

    cmd_select u_sel (
        .brake_clean   (clean_pins[0]),
        .dir_clean     (clean_pins[1]),
        .drvoff_clean  (clean_pins[2]),
        .brake_ovr_en  (brake_ovr_en),
        .brake_ovr_val (brake_ovr_val),
        .dir_ovr_en    (dir_ovr_en),
        .dir_ovr_val   (dir_ovr_val),
        .eff           (eff)
    );

    drive_fsm #(.SPD_W(SPD_W)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .eff           (eff),
        .brake_mode    (brake_mode),
        .brake_thr     (brake_thr),
        .speed_est     (speed_est),
        .seq_ack       (seq_ack),
        .state         (state),
        .brake_kind    (kind),
        .dir_fwd       (dir_fwd),
        .restart_pulse (restart_pulse),
        .coast         (coast)
    );

    speed_clamp #(.SPD_W(SPD_W)) u_clamp (
        .clk          (clk),
        .rst          (rst),
        .state        (state),
        .speed_req    (speed_req),
        .brake_thr    (brake_thr),
        .speed_target (speed_target)
    );

    assign drive_state = state;
    assign brake_kind  = kind;

    // R8
    kind_state_chk: assert property (@(posedge clk) disable iff (rst)
        (drive_state != 3'd2) |-> (brake_kind == 2'd0));

endmodule

// File: tb/sim_drive_cmd_arbiter.sv
module sim_drive_cmd_arbiter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       brake_pin = 0, dir_pin = 1, drvoff_pin = 0;
    logic       brake_ovr_en = 1, brake_ovr_val = 0;
    logic       dir_ovr_en = 1, dir_ovr_val = 1;
    logic       brake_mode = 0;
    logic [3:0] filt_len = 0;
    logic [7:0] brake_thr = 8, speed_est = 0, speed_req = 20;
    logic       seq_ack = 0;
    logic [7:0] speed_target;
    logic [2:0] drive_state;
    logic [1:0] brake_kind;
    logic       dir_fwd, restart_pulse, coast;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    drive_cmd_arbiter u0 (
        .clk(clk), .rst(rst), .brake_pin(brake_pin), .dir_pin(dir_pin),
        .drvoff_pin(drvoff_pin), .brake_ovr_en(brake_ovr_en),
        .brake_ovr_val(brake_ovr_val), .dir_ovr_en(dir_ovr_en),
        .dir_ovr_val(dir_ovr_val), .brake_mode(brake_mode),
        .filt_len(filt_len), .brake_thr(brake_thr), .speed_est(speed_est),
        .speed_req(speed_req), .seq_ack(seq_ack),
        .speed_target(speed_target), .drive_state(drive_state),
        .brake_kind(brake_kind), .dir_fwd(dir_fwd),
        .restart_pulse(restart_pulse), .coast(coast)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic ack_start();
        seq_ack = 1;
        step();
        seq_ack = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        // R11 reset state
        chk("R11 state", drive_state, 3);
        chk("R11 coast", coast, 1);
        chk("R11 restart", restart_pulse, 0);
        chk("R11 dir", dir_fwd, 1);
        chk("R11 target", speed_target, 0);
        chk("R11 kind", brake_kind, 0);
        rst = 0;
        step();
        // R4 coast exit enters restart with pulse
        chk("R4 state", drive_state, 4);
        chk("R4 pulse", restart_pulse, 1);
        chk("R5 coast held", coast, 1);
        step();
        chk("R4 pulse width", restart_pulse, 0);
        chk("R5 wait ack", drive_state, 4);
        ack_start();
        chk("R5 run", drive_state, 0);
        chk("R5 coast low", coast, 0);
        chk("R6 run target", speed_target, 20);

        // R6 R7 R8 R9 sweep
        for (int r = 0; r < 2; r++) begin
            for (int m = 0; m < 2; m++) begin
                for (int e = 0; e < 16; e++) begin
                    speed_req = (r == 0) ? 8'd5 : 8'd20;
                    brake_mode = m[0];
                    speed_est = 8'(e);
                    brake_ovr_val = 1;
                    step();
                    chk("R6 ramp", drive_state, 1);
                    chk("R6 clamp", speed_target, (r == 0) ? 5 : 8);
                    chk("R8 none", brake_kind, 0);
                    step();
                    if (e <= 8) begin
                        chk("R7 brake", drive_state, 2);
                        chk("R8 kind", brake_kind, m + 1);
                        chk("R8 zero", speed_target, 0);
                        step();
                        chk("R9 hold", drive_state, 2);
                        brake_ovr_val = 0;
                        step();
                        chk("R9 restart", drive_state, 4);
                        chk("R9 pulse", restart_pulse, 1);
                        ack_start();
                    end else begin
                        chk("R7 stay", drive_state, 1);
                        brake_ovr_val = 0;
                        step();
                    end
                    chk("R7 back run", drive_state, 0);
                end
            end
        end

        // R10 direction frozen while driven
        speed_est = 0;
        dir_ovr_val = 0;
        repeat (3) step();
        chk("R10 frozen run", dir_fwd, 1);
        brake_ovr_val = 1;
        step(); step();
        chk("R10 frozen brake", dir_fwd, 1);
        brake_ovr_val = 0;
        step();
        chk("R10 restart entry", dir_fwd, 1);
        step();
        chk("R10 applied", dir_fwd, 0);
        ack_start();
        chk("R10 run", drive_state, 0);

        // R2 override of brake pin
        brake_pin = 1;
        brake_ovr_val = 0;
        repeat (6) step();
        chk("R2 pin masked", drive_state, 0);
        brake_ovr_en = 0;
        step();
        chk("R2 pin used", drive_state, 1);
        brake_ovr_en = 1;
        step();
        chk("R2 override back", drive_state, 0);
        brake_pin = 0;
        repeat (4) step();

        // R3 drive-disable during brake, pin path with filt_len=0
        brake_ovr_val = 1;
        step(); step();
        chk("R3 in brake", drive_state, 2);
        drvoff_pin = 1;
        repeat (3) step();
        chk("R1 latency", drive_state, 2);
        step();
        chk("R3 coast", drive_state, 3);
        chk("R3 coast out", coast, 1);
        chk("R3 target", speed_target, 0);
        chk("R3 kind", brake_kind, 0);
        drvoff_pin = 0;
        repeat (3) step();
        chk("R1 release latency", drive_state, 3);
        step();
        chk("R4 restart", drive_state, 4);
        chk("R4 pulse2", restart_pulse, 1);
        ack_start();
        chk("R5 ack to ramp", drive_state, 1);
        brake_ovr_val = 0;
        step();
        chk("R7 release", drive_state, 0);

        // R1 glitch filter with filt_len=3
        filt_len = 3;
        drvoff_pin = 1;
        repeat (3) step();
        drvoff_pin = 0;
        repeat (10) step();
        chk("R1 glitch dropped", drive_state, 0);
        drvoff_pin = 1;
        repeat (6) step();
        chk("R1 before", drive_state, 0);
        step();
        chk("R1 after", drive_state, 3);
        drvoff_pin = 0;
        repeat (7) step();
        chk("R1 release", drive_state, 4);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule